// File: doc/BRIEF.md
# Crypto Coprocessor Command and FIFO Port

This block sits between a processor's load/store microcode and a small set of cipher and hash engines. Microcode writes a command made of a 4-bit opcode and an 8-bit function code. The block decodes the pair, picks one engine and enables only that one. It then feeds that engine from a 32-doubleword input queue and collects the engine's results into a 32-doubleword output queue. Microcode polls a set of status outputs to pace its loads and stores and to see when the operation is complete. Those outputs are: busy, suspended, done, invalid function, command overrun, engine error, input free entries and output occupancy.

Engines that the current command does not use are held disabled, and the queue buffers are enabled only while a command runs or results wait to be drained. An operation can be suspended. This freezes the engine and both queues. A later resume picks up from the same state, with no queued data lost.

Top module: `ccp_top`

## Requirements
- R1: After reset the block is idle: busy, suspended, done, invalid, overrun and engine-error flags are 0, input free count is 32, output count is 0, all engine enables, freeze and buffer enable are 0.
- R2: Opcode 1 (ECB) and 2 (CBC) with function bits [6:0] equal to 1 select engine 0, and equal to 2 or 3 select engine 1. Function bit 7 means decrypt. Opcode 3 (hash) with function code 8'h01 selects engine 2. An accepted command is presented to the engines as {opcode, function} on eng_cmd.
- R3: A command write while idle with any other opcode/function pair sets the invalid flag, leaves the block idle and enables no engine.
- R4: A command write while busy or suspended is ignored: eng_cmd and the running operation are unchanged, and the overrun flag is set.
- R5: Doublewords pushed while busy leave the input queue, in order, to the selected engine. Every result of that engine enters the output queue in order and is read at the head of the output queue.
- R6: While busy, exactly the selected engine's enable bit is 1 and all others are 0. The buffer enable is 1 while busy or while the output queue holds data. Input pushes while idle are ignored.
- R7: A done pulse from the selected engine while running ends the operation. Busy falls and done is set. The engine's error line at that pulse sets the engine-error flag.
- R8: A suspend pulse while running freezes the engine and both queues. The freeze output is 1, no data goes to the engine, and pushes and pops are ignored. A resume pulse continues the operation with every queued doubleword kept.
- R9: Status reports the input queue's free entries and the output queue's occupancy, each 6 bits. When the output queue holds 32 entries, the engine's results are held back until space appears.
- R10: Any command write while idle clears done, overrun, engine-error and the previous invalid flag before the new command's outcome is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_op | input | 4 | Opcode |
| cmd_fn | input | 8 | Function code |
| suspend | input | 1 | Suspend request pulse |
| resume | input | 1 | Resume request pulse |
| ifq_push | input | 1 | Push into input queue |
| ifq_wdata | input | 64 | Input doubleword |
| ofq_pop | input | 1 | Pop from output queue |
| ofq_rdata | output | 64 | Output queue head |
| sts_busy | output | 1 | Command active (running or suspended) |
| sts_susp | output | 1 | Operation suspended |
| sts_done | output | 1 | Last operation completed |
| sts_inval | output | 1 | Invalid opcode/function pair |
| sts_ovr | output | 1 | Command written while busy |
| sts_engerr | output | 1 | Engine reported an error |
| sts_ifq_free | output | 6 | Input queue free entries |
| sts_ofq_cnt | output | 6 | Output queue occupancy |
| buf_en | output | 1 | Queue buffer enable |
| eng_en | output | 3 | Per-engine enable |
| eng_freeze | output | 1 | Freeze the active engine |
| eng_cmd | output | 12 | Latched {opcode, function} |
| eng_din | output | 64 | Data to engines |
| eng_in_vld | output | 3 | Per-engine input valid |
| eng_in_rdy | input | 3 | Per-engine input ready |
| eng_dout | input | 192 | Engine results, engine i at bits [64i+63:64i] |
| eng_out_vld | input | 3 | Per-engine result valid |
| eng_out_rdy | output | 3 | Per-engine result ready |
| eng_done | input | 3 | Per-engine completion pulse |
| eng_err | input | 3 | Per-engine error, sampled with done |

## Verification
The bench builds the block with its default values: 64-bit data, a queue depth of 32 and three engines. At these values the bench can fill the output queue completely. A 40-doubleword hash job runs with draining held off, so the full-queue back-pressure and the exact free and occupancy counts at the boundary are reached. Three engines give every decode route its own engine model, each with its own data transform. A result routed to the wrong engine, or with the wrong decrypt setting, therefore shows up as a data mismatch on the scoreboard.

// File: rtl/ccp_pkg.sv
// Shared definitions for the crypto coprocessor port.
// Assumes exactly three engines: single-key cipher, triple-key cipher, hash.
package ccp_pkg;
    parameter int OP_W    = 4;
    parameter int FN_W    = 8;
    parameter int NUM_ENG = 3;

    localparam logic [OP_W-1:0] OP_ECB  = 4'd1;
    localparam logic [OP_W-1:0] OP_CBC  = 4'd2;
    localparam logic [OP_W-1:0] OP_HASH = 4'd3;

    localparam int ENG_SINGLE = 0;
    localparam int ENG_TRIPLE = 1;
    localparam int ENG_HASH   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2
    } ccp_state_e;
endpackage

// File: rtl/ccp_fifo.sv
// Synchronous show-ahead queue with flush.
// Assumes DEPTH is a power of two; push when full and pop when empty are dropped.
module ccp_fifo #(
    parameter int DW    = 64,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    assign rdata = mem[rp];
    assign count = cnt;
endmodule

// File: rtl/ccp_decode.sv
// Maps an opcode/function pair to a one-hot engine select.
// Assumes the engine index layout of ccp_pkg; anything unlisted is invalid.
module ccp_decode
    import ccp_pkg::*;
(
    input  logic [OP_W-1:0]    op,
    input  logic [FN_W-1:0]    fn,
    output logic               valid,
    output logic [NUM_ENG-1:0] sel
);
    logic [FN_W-2:0] alg;
    assign alg = fn[FN_W-2:0];

    // Pick the engine for this pair.
    always_comb begin
        valid = 1'b0;
        sel   = '0;
        if (op == OP_ECB || op == OP_CBC) begin
            if (alg == 7'd1) begin
                valid = 1'b1;
                sel[ENG_SINGLE] = 1'b1;
            end else if (alg == 7'd2 || alg == 7'd3) begin
                valid = 1'b1;
                sel[ENG_TRIPLE] = 1'b1;
            end
        end else if (op == OP_HASH && fn == 8'h01) begin
            valid = 1'b1;
            sel[ENG_HASH] = 1'b1;
        end
    end
endmodule

// File: rtl/ccp_ctrl.sv
// Command register, operation state machine and sticky status flags.
// Assumes done_in/err_in are already qualified by the selected engine.
module ccp_ctrl
    import ccp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [OP_W-1:0]      cmd_op,
    input  logic [FN_W-1:0]      cmd_fn,
    input  logic                 dec_valid,
    input  logic [NUM_ENG-1:0]   dec_sel,
    input  logic                 suspend,
    input  logic                 resume,
    input  logic                 done_in,
    input  logic                 err_in,
    output ccp_state_e           state,
    output logic [NUM_ENG-1:0]   sel_q,
    output logic [OP_W+FN_W-1:0] cmd_q,
    output logic                 accept,
    output logic                 done_q,
    output logic                 inval_q,
    output logic                 ovr_q,
    output logic                 err_q
);
    assign accept = (state == ST_IDLE) && cmd_wr && dec_valid;

    // State transitions, command latch and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_q   <= '0;
            cmd_q   <= '0;
            done_q  <= 1'b0;
            inval_q <= 1'b0;
            ovr_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        done_q  <= 1'b0;
                        ovr_q   <= 1'b0;
                        err_q   <= 1'b0;
                        inval_q <= !dec_valid;
                        if (dec_valid) begin
                            state <= ST_RUN;
                            sel_q <= dec_sel;
                            cmd_q <= {cmd_op, cmd_fn};
                        end
                    end
                end
                ST_RUN: begin
                    if (cmd_wr) ovr_q <= 1'b1;
                    if (done_in) begin
                        state  <= ST_IDLE;
                        sel_q  <= '0;
                        done_q <= 1'b1;
                        err_q  <= err_in;
                    end else if (suspend) begin
                        state <= ST_SUSP;
                    end
                end
                ST_SUSP: begin
                    if (cmd_wr) ovr_q <= 1'b1;
                    if (resume) state <= ST_RUN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ccp_top.sv
// Crypto coprocessor port: command dispatch, queues, engine routing, power gating.
// Assumes engines use valid/ready on both sides and pulse done once per operation.
module ccp_top
    import ccp_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_wr,
    input  logic [OP_W-1:0]         cmd_op,
    input  logic [FN_W-1:0]         cmd_fn,
    input  logic                    suspend,
    input  logic                    resume,
    input  logic                    ifq_push,
    input  logic [DW-1:0]           ifq_wdata,
    input  logic                    ofq_pop,
    output logic [DW-1:0]           ofq_rdata,
    output logic                    sts_busy,
    output logic                    sts_susp,
    output logic                    sts_done,
    output logic                    sts_inval,
    output logic                    sts_ovr,
    output logic                    sts_engerr,
    output logic [CNT_W-1:0]        sts_ifq_free,
    output logic [CNT_W-1:0]        sts_ofq_cnt,
    output logic                    buf_en,
    output logic [NUM_ENG-1:0]      eng_en,
    output logic                    eng_freeze,
    output logic [OP_W+FN_W-1:0]    eng_cmd,
    output logic [DW-1:0]           eng_din,
    output logic [NUM_ENG-1:0]      eng_in_vld,
    input  logic [NUM_ENG-1:0]      eng_in_rdy,
    input  logic [NUM_ENG*DW-1:0]   eng_dout,
    input  logic [NUM_ENG-1:0]      eng_out_vld,
    output logic [NUM_ENG-1:0]      eng_out_rdy,
    input  logic [NUM_ENG-1:0]      eng_done,
    input  logic [NUM_ENG-1:0]      eng_err
);
    ccp_state_e           state;
    logic [NUM_ENG-1:0]   sel_q, dec_sel;
    logic                 dec_valid, accept, run, busy, susp;
    logic                 done_sel, err_sel;
    logic                 ifq_full, ifq_empty, ofq_full, ofq_empty;
    logic                 ifq_wr, ifq_rd, ofq_wr, ofq_rd;
    logic [CNT_W-1:0]     ifq_cnt, ofq_cnt;
    logic [DW-1:0]        res_data;
    logic [DW-1:0]        res_masked [NUM_ENG];

    ccp_decode u_dec (
        .op    (cmd_op),
        .fn    (cmd_fn),
        .valid (dec_valid),
        .sel   (dec_sel)
    );

    ccp_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_op   (cmd_op),
        .cmd_fn   (cmd_fn),
        .dec_valid(dec_valid),
        .dec_sel  (dec_sel),
        .suspend  (suspend),
        .resume   (resume),
        .done_in  (done_sel),
        .err_in   (err_sel),
        .state    (state),
        .sel_q    (sel_q),
        .cmd_q    (eng_cmd),
        .accept   (accept),
        .done_q   (sts_done),
        .inval_q  (sts_inval),
        .ovr_q    (sts_ovr),
        .err_q    (sts_engerr)
    );

    assign run  = (state == ST_RUN);
    assign susp = (state == ST_SUSP);
    assign busy = run || susp;

    // Completion and error are taken only from the selected engine while running.
    assign done_sel = run && |(eng_done & sel_q);
    assign err_sel  = |(eng_err & sel_q);

    // Queue side gating: pushes only while running, pops blocked while frozen.
    assign ifq_wr = ifq_push && run;
    assign ifq_rd = run && !ifq_empty && |(sel_q & eng_in_rdy);
    assign ofq_wr = |(eng_out_vld & eng_out_rdy);
    assign ofq_rd = ofq_pop && !susp;

    ccp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_ifq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (accept),
        .push  (ifq_wr),
        .wdata (ifq_wdata),
        .pop   (ifq_rd),
        .rdata (eng_din),
        .count (ifq_cnt),
        .full  (ifq_full),
        .empty (ifq_empty)
    );

    ccp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_ofq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .push  (ofq_wr),
        .wdata (res_data),
        .pop   (ofq_rd),
        .rdata (ofq_rdata),
        .count (ofq_cnt),
        .full  (ofq_full),
        .empty (ofq_empty)
    );

    // Per-engine handshakes and result masking.
    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        assign eng_in_vld[g]  = sel_q[g] && run && !ifq_empty;
        assign eng_out_rdy[g] = sel_q[g] && run && !ofq_full;
        assign res_masked[g]  = sel_q[g] ? eng_dout[g*DW +: DW] : '0;
    end

    // Merge the selected engine's result onto the output queue input.
    always_comb begin
        res_data = '0;
        for (int i = 0; i < NUM_ENG; i++) res_data = res_data | res_masked[i];
    end

    assign eng_en       = sel_q;
    assign eng_freeze   = susp;
    assign buf_en       = busy || !ofq_empty;
    assign sts_busy     = busy;
    assign sts_susp     = susp;
    assign sts_ifq_free = CNT_W'(DEPTH) - ifq_cnt;
    assign sts_ofq_cnt  = ofq_cnt;

    logic unused_ok;
    assign unused_ok = ifq_full;
endmodule

// File: rtl/ccp_chk.sv
// Protocol checker for ccp_top, attached by bind.
// Assumes it observes only the top module's ports.
module ccp_chk #(
    parameter int NUM_ENG = 3,
    parameter int DEPTH   = 32,
    parameter int CNT_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_wr,
    input logic               resume,
    input logic               sts_busy,
    input logic               sts_susp,
    input logic               sts_inval,
    input logic               sts_ovr,
    input logic [CNT_W-1:0]   sts_ifq_free,
    input logic [CNT_W-1:0]   sts_ofq_cnt,
    input logic [NUM_ENG-1:0] eng_en,
    input logic [NUM_ENG-1:0] eng_in_vld,
    input logic               eng_freeze
);
    // R6
    eng_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_en));

    // R6
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_busy |-> (eng_en == '0));

    // R8
    frz_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_freeze |-> (eng_in_vld == '0));

    // R8
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_susp && !resume) |=> ($stable(sts_ifq_free) && $stable(sts_ofq_cnt)));

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_busy && cmd_wr) |=> sts_ovr);

    // R3
    inval_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_inval |-> !sts_busy);

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_ofq_cnt <= CNT_W'(DEPTH)) && (sts_ifq_free <= CNT_W'(DEPTH)));

    // R5
    feed_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_in_vld != '0) |-> (sts_busy && !sts_susp));
endmodule

bind ccp_top ccp_chk #(.NUM_ENG(ccp_pkg::NUM_ENG), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ccp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .resume      (resume),
    .sts_busy    (sts_busy),
    .sts_susp    (sts_susp),
    .sts_inval   (sts_inval),
    .sts_ovr     (sts_ovr),
    .sts_ifq_free(sts_ifq_free),
    .sts_ofq_cnt (sts_ofq_cnt),
    .eng_en      (eng_en),
    .eng_in_vld  (eng_in_vld),
    .eng_freeze  (eng_freeze)
);

// File: tb/test_ccp_top.sv
// Scoreboard bench: the push driver queues expected results, a monitor pops and compares.
module test_ccp_top;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 3;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [7:0] cmd_fn = '0;
    logic suspend = 1'b0, resume = 1'b0;
    logic ifq_push = 1'b0;
    logic [DW-1:0] ifq_wdata = '0;
    logic ofq_pop = 1'b0;
    logic [DW-1:0] ofq_rdata;
    logic sts_busy, sts_susp, sts_done, sts_inval, sts_ovr, sts_engerr;
    logic [5:0] sts_ifq_free, sts_ofq_cnt;
    logic buf_en, eng_freeze;
    logic [NE-1:0] eng_en, eng_in_vld, eng_in_rdy, eng_out_vld, eng_out_rdy, eng_done, eng_err;
    logic [11:0] eng_cmd;
    logic [DW-1:0] eng_din;
    logic [NE*DW-1:0] eng_dout;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] sb [$];
    logic mon_en = 1'b1;
    logic err_inject = 1'b0;

    // Engine models
    logic [NE-1:0] m_bufv = '0;
    logic [NE-1:0] m_done = '0;
    logic [DW-1:0] m_bufd [NE];
    int m_cnt [NE];
    int want [NE];

    always #(CLK_PERIOD/2) clk = ~clk;

    ccp_top i_ccp_top (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_fn(cmd_fn),
        .suspend(suspend), .resume(resume), .ifq_push(ifq_push), .ifq_wdata(ifq_wdata),
        .ofq_pop(ofq_pop), .ofq_rdata(ofq_rdata), .sts_busy(sts_busy), .sts_susp(sts_susp),
        .sts_done(sts_done), .sts_inval(sts_inval), .sts_ovr(sts_ovr), .sts_engerr(sts_engerr),
        .sts_ifq_free(sts_ifq_free), .sts_ofq_cnt(sts_ofq_cnt), .buf_en(buf_en),
        .eng_en(eng_en), .eng_freeze(eng_freeze), .eng_cmd(eng_cmd), .eng_din(eng_din),
        .eng_in_vld(eng_in_vld), .eng_in_rdy(eng_in_rdy), .eng_dout(eng_dout),
        .eng_out_vld(eng_out_vld), .eng_out_rdy(eng_out_rdy), .eng_done(eng_done),
        .eng_err(eng_err)
    );

    function automatic logic [DW-1:0] xf(int e, logic [DW-1:0] d, logic dec);
        logic [DW-1:0] k;
        case (e)
            0: k = 64'h0123_4567_89AB_CDEF;
            1: k = 64'h5A5A_3C3C_0F0F_9696;
            default: k = 64'hF0E1_D2C3_B4A5_9687;
        endcase
        return d ^ k ^ (dec ? '1 : '0);
    endfunction

    assign eng_in_rdy  = ~m_bufv;
    assign eng_out_vld = m_bufv & {NE{~eng_freeze}};
    assign eng_done    = m_done;
    assign eng_err     = m_done & {NE{err_inject}};

    always_comb begin
        for (int i = 0; i < NE; i++) eng_dout[i*DW +: DW] = m_bufd[i];
    end

    // Behavioural engines: one-entry buffer, transform, done after the wanted count.
    always @(posedge clk) begin
        for (int i = 0; i < NE; i++) begin
            if (!rst_n || !eng_en[i]) begin
                m_bufv[i] <= 1'b0;
                m_cnt[i]  <= 0;
                m_done[i] <= 1'b0;
            end else begin
                if (eng_out_vld[i] && eng_out_rdy[i]) m_bufv[i] <= 1'b0;
                if (eng_in_vld[i] && eng_in_rdy[i]) begin
                    m_bufv[i] <= 1'b1;
                    m_bufd[i] <= xf(i, eng_din, eng_cmd[7]);
                    m_cnt[i]  <= m_cnt[i] + 1;
                end
                m_done[i] <= !eng_freeze && !m_done[i] && (m_cnt[i] == want[i]) && !m_bufv[i];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pop and compare against the scoreboard (R5).
    always @(negedge clk) begin
        if (rst_n && mon_en && !sts_susp && sts_ofq_cnt != 0) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R5 unexpected result", ofq_rdata, '0);
            end else begin
                logic [DW-1:0] e;
                e = sb.pop_front();
                chk(ofq_rdata == e, "R5 result data", ofq_rdata, e);
            end
            ofq_pop = 1'b1;
        end else begin
            ofq_pop = 1'b0;
        end
    end

    task automatic write_cmd(input logic [3:0] op, input logic [7:0] fn);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_op = op; cmd_fn = fn;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic push_words(input int n, input int eng, input logic dec, input int tag);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            ifq_push  = 1'b1;
            ifq_wdata = {16'hC0DE, 16'(tag), 32'(j) * 32'h9E37_79B1};
            sb.push_back(xf(eng, ifq_wdata, dec));
        end
        @(negedge clk);
        ifq_push = 1'b0;
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk);
        s = 1'b1;
        @(negedge clk);
        s = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while ((sts_busy || sts_ofq_cnt != 0 || sb.size() != 0) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 2000, tag, 64'(n), 64'd2000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] f0, c0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({sts_busy, sts_susp, sts_done, sts_inval, sts_ovr, sts_engerr} == 6'b0, "R1 flags",
            64'({sts_busy, sts_susp, sts_done, sts_inval, sts_ovr, sts_engerr}), 0);
        chk(sts_ifq_free == 6'd32 && sts_ofq_cnt == 6'd0, "R1 counts", 64'({sts_ifq_free, sts_ofq_cnt}), 64'({6'd32, 6'd0}));
        chk(eng_en == '0 && !eng_freeze && !buf_en, "R1 enables", 64'({eng_en, eng_freeze, buf_en}), 0);

        // R6 push while idle is ignored
        @(negedge clk); ifq_push = 1'b1; ifq_wdata = 64'hDEAD;
        @(negedge clk); ifq_push = 1'b0;
        @(negedge clk);
        chk(sts_ifq_free == 6'd32, "R6 idle push ignored", 64'(sts_ifq_free), 32);

        // R2 ECB single-key encrypt on engine 0
        want[0] = 8;
        write_cmd(4'd1, 8'h01);
        chk(sts_busy && eng_en == 3'b001, "R2 ECB select", 64'(eng_en), 1);
        chk(eng_cmd == 12'h101, "R2 eng_cmd", 64'(eng_cmd), 64'h101);
        chk(buf_en, "R6 buffers on while busy", 64'(buf_en), 1);
        push_words(8, 0, 1'b0, 1);
        wait_idle("R5 ECB drain");
        chk(sts_done && !sts_busy, "R7 done set", 64'({sts_done, sts_busy}), 64'b10);
        chk(eng_en == '0 && !buf_en, "R6 all off when idle", 64'({eng_en, buf_en}), 0);

        // R2/R4 CBC triple-key decrypt on engine 1, overrun mid-run
        want[1] = 6;
        write_cmd(4'd2, 8'h83);
        chk(eng_en == 3'b010 && !sts_done, "R2 CBC select", 64'(eng_en), 2);
        push_words(3, 1, 1'b1, 2);
        write_cmd(4'd3, 8'h01);
        chk(sts_ovr && eng_cmd == 12'h283 && eng_en == 3'b010, "R4 overrun ignored", 64'(eng_cmd), 64'h283);
        push_words(3, 1, 1'b1, 3);
        wait_idle("R4 CBC drain after overrun");

        // R3 invalid pairs
        write_cmd(4'd3, 8'h81);
        chk(sts_inval && !sts_busy && eng_en == '0, "R3 hash with decrypt", 64'({sts_inval, sts_busy, eng_en}), 64'b10000);
        write_cmd(4'd5, 8'h01);
        chk(sts_inval && !sts_busy, "R3 unknown opcode", 64'(sts_inval), 1);
        write_cmd(4'd1, 8'h04);
        chk(sts_inval && eng_en == '0, "R3 unknown algorithm", 64'(eng_en), 0);

        // R9 full output queue back-pressure on the hash engine
        mon_en = 1'b0;
        want[2] = 40;
        write_cmd(4'd3, 8'h01);
        chk(!sts_inval && eng_en == 3'b100, "R10 inval cleared, R2 hash select", 64'({sts_inval, eng_en}), 64'b0100);
        push_words(40, 2, 1'b0, 4);
        repeat (150) @(negedge clk);
        chk(sts_ofq_cnt == 6'd32, "R9 output full count", 64'(sts_ofq_cnt), 32);
        chk(sts_ifq_free == 6'd25, "R9 input free count", 64'(sts_ifq_free), 25);
        chk(sts_busy, "R9 held while full", 64'(sts_busy), 1);
        mon_en = 1'b1;
        wait_idle("R9 drain after full");

        // R8 suspend and resume on engine 1
        want[1] = 20;
        write_cmd(4'd1, 8'h02);
        push_words(10, 1, 1'b0, 5);
        pulse(suspend);
        chk(sts_susp && eng_freeze && eng_in_vld == '0, "R8 frozen", 64'({sts_susp, eng_freeze, eng_in_vld}), 64'b11000);
        f0 = sts_ifq_free; c0 = sts_ofq_cnt;
        @(negedge clk); ifq_push = 1'b1; ifq_wdata = 64'hBAD0;
        @(negedge clk); ifq_push = 1'b0;
        repeat (8) @(negedge clk);
        chk(sts_ifq_free == f0 && sts_ofq_cnt == c0, "R8 queues held", 64'({sts_ifq_free, sts_ofq_cnt}), 64'({f0, c0}));
        chk(sts_busy && sts_susp, "R8 still suspended", 64'({sts_busy, sts_susp}), 3);
        pulse(resume);
        chk(!sts_susp && !eng_freeze, "R8 resumed", 64'({sts_susp, eng_freeze}), 0);
        push_words(10, 1, 1'b0, 6);
        wait_idle("R8 drain after resume");

        // R7 engine error
        err_inject = 1'b1;
        want[0] = 4;
        write_cmd(4'd2, 8'h01);
        push_words(4, 0, 1'b0, 7);
        wait_idle("R7 error run drain");
        chk(sts_done && sts_engerr, "R7 engine error", 64'({sts_done, sts_engerr}), 3);
        err_inject = 1'b0;

        // R10 idle write clears sticky flags
        write_cmd(4'd0, 8'h00);
        chk(!sts_done && !sts_engerr && !sts_ovr && sts_inval, "R10 flags cleared", 64'({sts_done, sts_engerr, sts_ovr, sts_inval}), 1);

        chk(sb.size() == 0, "R5 scoreboard empty", 64'(sb.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule